// File: doc/BRIEF.md
# Dual Ramp Envelope Generator

This block runs two linear ramp envelopes side by side. One sets the modulation gain of a synthesis voice and the other sets its output volume. Each envelope holds a 6-bit level. While it is enabled, the level moves one step up or down each time its step timer expires. The step period is the envelope's own speed field multiplied by a shared master speed, then scaled by eight input clocks. A disabled envelope does not ramp. Its level is loaded straight from the speed field of the control byte.

Software reaches the block through one write port. Address 0 takes the volume control byte, address 1 takes the modulation control byte and address 2 takes the master speed. Two halt flags come from elsewhere in the voice, and either one freezes both ramps. A clock enable marks the input clocks that the timers count. Both levels are brought out directly, and each also has an 8-bit readback form that has bit 6 set.

Top module: `dual_ramp_env`

## Requirements
- R1: Address map: 0 is the volume control byte, 1 is the modulation control byte, 2 is the master speed, and writes to address 3 change nothing. In a control byte, bit 7 set means disabled, bit 6 set means ramp upward (clear means downward), and bits 5:0 are the speed.
- R2: A control write with bit 7 set makes that envelope's level equal to bits 5:0 of the written byte from the next cycle on.
- R3: An enabled envelope steps its level by one after exactly ((speed + 1) * master) * 8 clock-enabled cycles, counted from the last clear of its timer. Leftover counts carry into the next period.
- R4: An upward ramp adds one only while the level is below 32. A level at 32 or above never rises without a write.
- R5: A downward ramp subtracts one only while the level is above 0. It never wraps below 0.
- R6: While envHalt is high, neither level changes and both timers are held at zero. A full period is needed after envHalt is released.
- R7: While waveHalt is high, neither level changes and the timers keep their counts.
- R8: While the master speed is 0, neither level changes.
- R9: A write to the master speed clears both envelope timers.
- R10: A control write clears that envelope's timer. When bit 7 is clear, the write leaves the level unchanged.
- R11: After reset, both levels are 0, both envelopes are disabled and the master speed is 0xFF.
- R12: Each readback output equals its level with bit 6 set and bit 7 clear.
- R13: Cycles with clkEn low do not advance the timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Marks an input clock that the envelope timers count |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| envHalt | input | 1 | Envelope halt flag; also clears both timers |
| waveHalt | input | 1 | Wave halt flag; freezes both envelopes |
| volLevel | output | 6 | Current volume envelope level |
| modLevel | output | 6 | Current modulation envelope level |
| volReadback | output | 8 | Volume level with bit 6 set |
| modReadback | output | 8 | Modulation level with bit 6 set |

## Verification
The assertions assume that wrAddr and wrData are valid in any cycle where wrEn is high, and that the halt flags and clkEn are never unknown once reset is released. They also assume that a level changes only on a timer expiry or a write. The bench respects these assumptions. It changes every input only on the falling edge, issues writes one at a time for a single cycle, and holds both halt flags high through reset, as the surrounding voice would. Step timing is checked by counting falling edges from the write that cleared the timer. This puts the sample one cycle before and exactly at the expected expiry.

// File: rtl/dual_env_pkg.sv
package dual_env_pkg;

  localparam int ENV_COUNT = 2;
  localparam int LEVEL_W   = 6;
  localparam int MSPEED_W  = 8;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;

  // envelope index doubles as its control register address
  localparam int ENV_VOL = 0;
  localparam int ENV_MOD = 1;

  typedef struct packed {
    logic [ENV_COUNT-1:0] clrTimer;
    logic [ENV_COUNT-1:0] forceLevel;
    logic [ENV_COUNT-1:0] stepEn;
    logic [LEVEL_W-1:0]   loadValue;
  } envStrobe_t;

endpackage

// File: rtl/env_ctrl.sv
module env_ctrl
  import dual_env_pkg::*;
#(
  parameter int NUM_ENV = ENV_COUNT,
  parameter int LVL_W   = LEVEL_W,
  parameter int MSPD_W  = MSPEED_W,
  parameter int A_W     = ADDR_W,
  parameter int D_W     = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clkEn,
  input  logic                   wrEn,
  input  logic [A_W-1:0]         wrAddr,
  input  logic [D_W-1:0]         wrData,
  input  logic                   envHalt,
  input  logic                   waveHalt,
  output envStrobe_t             strobe,
  output logic [NUM_ENV-1:0]     rampUp,
  output logic [NUM_ENV*LVL_W-1:0] speedFlat,
  output logic [MSPD_W-1:0]      masterSpeed
);

  localparam int DIS_BIT     = D_W - 1;
  localparam int DIR_BIT     = D_W - 2;
  localparam int MASTER_ADDR = NUM_ENV;

  logic                 selMaster;
  logic                 runOk;
  logic [NUM_ENV-1:0]   envOff;
  logic [NUM_ENV-1:0]   clrVec;
  logic [NUM_ENV-1:0]   forceVec;
  logic [NUM_ENV-1:0]   stepVec;

  assign selMaster = wrEn && (wrAddr == A_W'(MASTER_ADDR));
  assign runOk     = clkEn && !envHalt && !waveHalt && (masterSpeed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masterSpeed <= '1;
    end else if (selMaster) begin
      masterSpeed <= wrData[MSPD_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_ENV; i++) begin : g_envReg
    logic selCtrl;
    assign selCtrl = wrEn && (wrAddr == A_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        envOff[i]                    <= 1'b1;
        rampUp[i]                    <= 1'b0;
        speedFlat[i*LVL_W +: LVL_W]  <= '0;
      end else if (selCtrl) begin
        envOff[i]                    <= wrData[DIS_BIT];
        rampUp[i]                    <= wrData[DIR_BIT];
        speedFlat[i*LVL_W +: LVL_W]  <= wrData[LVL_W-1:0];
      end
    end

    assign clrVec[i]   = selCtrl || selMaster || envHalt;
    assign forceVec[i] = selCtrl && wrData[DIS_BIT];
    assign stepVec[i]  = runOk && !envOff[i];
  end

  always_comb begin
    strobe.clrTimer   = clrVec;
    strobe.forceLevel = forceVec;
    strobe.stepEn     = stepVec;
    strobe.loadValue  = wrData[LVL_W-1:0];
  end

endmodule

// File: rtl/env_channel.sv
module env_channel #(
  parameter int LVL_W     = 6,
  parameter int MSPD_W    = 8,
  parameter int TICK_SH   = 3,
  parameter int SAT_LEVEL = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clrTimer,
  input  logic              forceLevel,
  input  logic              stepEn,
  input  logic [LVL_W-1:0]  loadValue,
  input  logic [LVL_W-1:0]  speed,
  input  logic              rampUp,
  input  logic [MSPD_W-1:0] masterSpeed,
  output logic [LVL_W-1:0]  level
);

  localparam int PERIOD_W = LVL_W + 1 + MSPD_W + TICK_SH;

  logic [LVL_W:0]    speedPlus;
  logic [PERIOD_W-1:0] period;
  logic [PERIOD_W-1:0] timer;
  logic [PERIOD_W-1:0] timerInc;
  logic                expire;

  assign speedPlus = {1'b0, speed} + 1'b1;
  assign period    = (PERIOD_W'(speedPlus) * PERIOD_W'(masterSpeed)) << TICK_SH;
  assign timerInc  = timer + 1'b1;
  assign expire    = timerInc >= period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (clrTimer) begin
      timer <= '0;
    end else if (stepEn) begin
      timer <= expire ? (timerInc - period) : timerInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else if (forceLevel) begin
      level <= loadValue;
    end else if (stepEn && expire && !clrTimer) begin
      if (rampUp) begin
        if (level < LVL_W'(SAT_LEVEL)) level <= level + 1'b1;
      end else begin
        if (level != '0) level <= level - 1'b1;
      end
    end
  end

endmodule

// File: rtl/env_datapath.sv
module env_datapath
  import dual_env_pkg::*;
#(
  parameter int NUM_ENV = ENV_COUNT,
  parameter int LVL_W   = LEVEL_W,
  parameter int MSPD_W  = MSPEED_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  envStrobe_t               strobe,
  input  logic [NUM_ENV-1:0]       rampUp,
  input  logic [NUM_ENV*LVL_W-1:0] speedFlat,
  input  logic [MSPD_W-1:0]        masterSpeed,
  output logic [NUM_ENV*LVL_W-1:0] levelFlat
);

  for (genvar i = 0; i < NUM_ENV; i++) begin : g_chan
    env_channel #(
      .LVL_W     (LVL_W),
      .MSPD_W    (MSPD_W),
      .TICK_SH   (3),
      .SAT_LEVEL (32)
    ) i_env_channel (
      .clk         (clk),
      .rst_n       (rst_n),
      .clrTimer    (strobe.clrTimer[i]),
      .forceLevel  (strobe.forceLevel[i]),
      .stepEn      (strobe.stepEn[i]),
      .loadValue   (strobe.loadValue),
      .speed       (speedFlat[i*LVL_W +: LVL_W]),
      .rampUp      (rampUp[i]),
      .masterSpeed (masterSpeed),
      .level       (levelFlat[i*LVL_W +: LVL_W])
    );
  end

endmodule

// File: rtl/dual_ramp_env.sv
module dual_ramp_env
  import dual_env_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clkEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               envHalt,
  input  logic               waveHalt,
  output logic [LEVEL_W-1:0] volLevel,
  output logic [LEVEL_W-1:0] modLevel,
  output logic [DATA_W-1:0]  volReadback,
  output logic [DATA_W-1:0]  modReadback
);

  localparam logic [DATA_W-1:0] READ_MARK = DATA_W'(1) << LEVEL_W;

  envStrobe_t                     strobe;
  logic [ENV_COUNT-1:0]           rampUp;
  logic [ENV_COUNT*LEVEL_W-1:0]   speedFlat;
  logic [ENV_COUNT*LEVEL_W-1:0]   levelFlat;
  logic [MSPEED_W-1:0]            masterSpeed;

  env_ctrl i_env_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clkEn       (clkEn),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .envHalt     (envHalt),
    .waveHalt    (waveHalt),
    .strobe      (strobe),
    .rampUp      (rampUp),
    .speedFlat   (speedFlat),
    .masterSpeed (masterSpeed)
  );

  env_datapath i_env_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .rampUp      (rampUp),
    .speedFlat   (speedFlat),
    .masterSpeed (masterSpeed),
    .levelFlat   (levelFlat)
  );

  assign volLevel    = levelFlat[ENV_VOL*LEVEL_W +: LEVEL_W];
  assign modLevel    = levelFlat[ENV_MOD*LEVEL_W +: LEVEL_W];
  assign volReadback = READ_MARK | DATA_W'(volLevel);
  assign modReadback = READ_MARK | DATA_W'(modLevel);

endmodule

// File: rtl/dual_ramp_env_chk.sv
module dual_ramp_env_chk
  import dual_env_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clkEn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               envHalt,
  input logic               waveHalt,
  input logic [LEVEL_W-1:0] volLevel,
  input logic [LEVEL_W-1:0] modLevel,
  input logic [MSPEED_W-1:0] masterSpeed
);

  localparam logic [ADDR_W-1:0] VOL_ADDR = ADDR_W'(ENV_VOL);
  localparam logic [ADDR_W-1:0] MOD_ADDR = ADDR_W'(ENV_MOD);

  // R2: disabled control write loads the speed field into the level
  assert_force_vol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == VOL_ADDR && wrData[DATA_W-1]) |=> (volLevel == $past(wrData[LEVEL_W-1:0])));

  assert_force_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == MOD_ADDR && wrData[DATA_W-1]) |=> (modLevel == $past(wrData[LEVEL_W-1:0])));

  // R3: without a write a level moves by at most one per cycle
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> (volLevel == $past(volLevel) ||
               volLevel == LEVEL_W'($past(volLevel) + 1) ||
               volLevel == LEVEL_W'($past(volLevel) - 1)));

  // R4: at or above the ceiling a level never rises on its own
  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && modLevel >= LEVEL_W'(32)) |=> (modLevel <= $past(modLevel)));

  assert_saturate_vol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && volLevel >= LEVEL_W'(32)) |=> (volLevel <= $past(volLevel)));

  // R5: a zero level never wraps downward
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && modLevel == '0) |=> (modLevel <= LEVEL_W'(1)));

  // R6: envelope halt freezes both levels
  assert_env_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (envHalt && !wrEn) |=> ($stable(volLevel) && $stable(modLevel)));

  // R7: wave halt freezes both levels
  assert_wave_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waveHalt && !wrEn) |=> ($stable(volLevel) && $stable(modLevel)));

  // R8: a zero master speed freezes both levels
  assert_master_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (masterSpeed == '0 && !wrEn) |=> ($stable(volLevel) && $stable(modLevel)));

  // R13: idle clock-enable cycles leave both levels alone
  assert_clk_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEn && !wrEn) |=> ($stable(volLevel) && $stable(modLevel)));

endmodule

bind dual_ramp_env dual_ramp_env_chk i_dual_ramp_env_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clkEn       (clkEn),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .envHalt     (envHalt),
  .waveHalt    (waveHalt),
  .volLevel    (volLevel),
  .modLevel    (modLevel),
  .masterSpeed (masterSpeed)
);

// File: tb/test_dual_ramp_env.sv
`timescale 1ns/1ps
module test_dual_ramp_env;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clkEn;
  logic       wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic       envHalt;
  logic       waveHalt;
  logic [5:0] volLevel;
  logic [5:0] modLevel;
  logic [7:0] volReadback;
  logic [7:0] modReadback;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_ramp_env i_dual_ramp_env (
    .clk         (clk),
    .rst_n       (rst_n),
    .clkEn       (clkEn),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .envHalt     (envHalt),
    .waveHalt    (waveHalt),
    .volLevel    (volLevel),
    .modLevel    (modLevel),
    .volReadback (volReadback),
    .modReadback (modReadback)
  );

  function automatic int periodOf(int spd, int mst);
    return (spd + 1) * mst * 8;
  endfunction

  task automatic checkVal(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    checkVal("R11", "vol after reset", volLevel, 0);
    checkVal("R11", "mod after reset", modLevel, 0);
    checkVal("R12", "vol readback after reset", volReadback, 8'h40);
    checkVal("R12", "mod readback after reset", modReadback, 8'h40);
  endtask

  task automatic testForceLoad();
    writeReg(2'd0, 8'h80 | 8'd45);
    checkVal("R2", "vol forced", volLevel, 45);
    checkVal("R12", "vol readback", volReadback, 8'h40 | 45);
    writeReg(2'd1, 8'hBF);
    checkVal("R2", "mod forced", modLevel, 63);
    checkVal("R1", "vol untouched by mod write", volLevel, 45);
  endtask

  task automatic testIgnoredAddr();
    writeReg(2'd3, 8'hC5);
    runCycles(3);
    checkVal("R1", "vol after addr3", volLevel, 45);
    checkVal("R1", "mod after addr3", modLevel, 63);
  endtask

  task automatic testRampUp();
    writeReg(2'd2, 8'd1);
    writeReg(2'd0, 8'h80 | 8'd30);
    writeReg(2'd0, 8'h40);
    checkVal("R10", "enable write keeps level", volLevel, 30);
    runCycles(periodOf(0, 1) - 1);
    checkVal("R3", "before expiry", volLevel, 30);
    runCycles(1);
    checkVal("R3", "at expiry", volLevel, 31);
    runCycles(periodOf(0, 1));
    checkVal("R4", "reach ceiling", volLevel, 32);
    runCycles(2 * periodOf(0, 1));
    checkVal("R4", "hold ceiling", volLevel, 32);
  endtask

  task automatic testRampDown();
    writeReg(2'd2, 8'd3);
    writeReg(2'd1, 8'h80 | 8'd5);
    writeReg(2'd1, 8'h02);
    runCycles(periodOf(2, 3) - 1);
    checkVal("R3", "scaled period before", modLevel, 5);
    runCycles(1);
    checkVal("R3", "scaled period at", modLevel, 4);
    runCycles(4 * periodOf(2, 3));
    checkVal("R5", "reach zero", modLevel, 0);
    runCycles(200);
    checkVal("R5", "hold zero", modLevel, 0);
  endtask

  task automatic testMasterClear();
    writeReg(2'd2, 8'd1);
    writeReg(2'd1, 8'h80 | 8'd10);
    writeReg(2'd1, 8'h00);
    runCycles(5);
    writeReg(2'd2, 8'd1);
    runCycles(7);
    checkVal("R9", "master write restarts timer", modLevel, 10);
    runCycles(1);
    checkVal("R9", "step after restart", modLevel, 9);
  endtask

  task automatic testCtrlClear();
    runCycles(3);
    writeReg(2'd1, 8'h00);
    checkVal("R10", "rewrite keeps level", modLevel, 9);
    runCycles(7);
    checkVal("R10", "rewrite restarts timer", modLevel, 9);
    runCycles(1);
    checkVal("R10", "step after rewrite", modLevel, 8);
  endtask

  task automatic testEnvHalt();
    runCycles(5);
    envHalt = 1'b1;
    runCycles(20);
    checkVal("R6", "frozen by envHalt", modLevel, 8);
    envHalt = 1'b0;
    runCycles(7);
    checkVal("R6", "timer cleared by envHalt", modLevel, 8);
    runCycles(1);
    checkVal("R6", "step after envHalt", modLevel, 7);
  endtask

  task automatic testWaveHalt();
    runCycles(5);
    waveHalt = 1'b1;
    runCycles(20);
    checkVal("R7", "frozen by waveHalt", modLevel, 7);
    waveHalt = 1'b0;
    runCycles(2);
    checkVal("R7", "timer kept through waveHalt", modLevel, 7);
    runCycles(1);
    checkVal("R7", "step after waveHalt", modLevel, 6);
  endtask

  task automatic testMasterZero();
    writeReg(2'd2, 8'd0);
    runCycles(50);
    checkVal("R8", "frozen by zero master", modLevel, 6);
    writeReg(2'd2, 8'd1);
    runCycles(7);
    checkVal("R8", "no early step", modLevel, 6);
    runCycles(1);
    checkVal("R8", "step after master restore", modLevel, 5);
  endtask

  task automatic testClkEn();
    runCycles(2);
    clkEn = 1'b0;
    runCycles(30);
    checkVal("R13", "idle enable", modLevel, 5);
    clkEn = 1'b1;
    runCycles(5);
    checkVal("R13", "count resumes", modLevel, 5);
    runCycles(1);
    checkVal("R13", "step after resume", modLevel, 4);
  endtask

  task automatic testAboveCeiling();
    writeReg(2'd0, 8'h80 | 8'd50);
    writeReg(2'd0, 8'h40);
    runCycles(40);
    checkVal("R4", "above ceiling no rise", volLevel, 50);
    writeReg(2'd0, 8'h00);
    runCycles(7);
    checkVal("R5", "down from 50 before", volLevel, 50);
    runCycles(1);
    checkVal("R5", "down from 50 at", volLevel, 49);
    checkVal("R12", "readback 49", volReadback, 8'h40 | 49);
  endtask

  initial begin
    rst_n = 1'b0; clkEn = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    envHalt = 1'b1; waveHalt = 1'b1;
    runCycles(3);
    rst_n = 1'b1;
    runCycles(1);
    testReset();
    envHalt = 1'b0; waveHalt = 1'b0; clkEn = 1'b1;
    testForceLoad();
    testIgnoredAddr();
    testRampUp();
    testRampDown();
    testMasterClear();
    testCtrlClear();
    testEnvHalt();
    testWaveHalt();
    testMasterZero();
    testClkEn();
    testAboveCeiling();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule